// File: doc/BRIEF.md
# Parallel-In Serial-Out Shifter with Clock Inhibit

This block converts a parallel word into a serial bit stream. A low level on the load input copies the parallel word into a chain of stages at once, without waiting for a clock edge. Once load is released, each rising clock edge moves every stage one place toward the output end. The serial input refills the stage at the input end. A high level on the inhibit input makes clock edges leave the chain unchanged, so the stream can pause without a separate enable mode.

The stages are named A (index 0, the input end) through H (index WIDTH-1, the output end). The serial output is stage H, and its complement is also brought out. A synchronous active-high reset clears the chain. A typical use is to load a byte, release load, and then apply WIDTH uninhibited clocks. The byte then appears most significant bit first, from stage H back to stage A.

Top module: `piso_shifter`

## Requirements
- R1: WIDTH defaults to 8. Parallel bit par_in[i] loads stage i, stage 0 is the input end, and ser_out is stage WIDTH-1.
- R2: When load_n falls, ser_out shows par_in[WIDTH-1] before any clock edge arrives.
- R3: Load has the highest priority. While load_n is low, the chain holds par_in across rising clock edges whatever the values of rst, inhibit and ser_in. The first rising edge after load_n returns high shifts as usual.
- R4: On a rising edge with load_n high, rst low and inhibit low, stage i+1 takes the old value of stage i, and stage 0 takes ser_in.
- R5: After byte D is loaded and released, ser_out equals D[7-k] after k uninhibited edges, for k = 0..7. After edge 8 it shows the first serial-input bit that was shifted in.
- R6: On a rising edge with inhibit high, load_n high and rst low, no stage changes.
- R7: ser_out_n is always the inverse of ser_out.
- R8: On a rising edge with rst high and load_n high, every stage becomes 0, even when inhibit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Asynchronous active-low parallel load |
| inhibit | input | 1 | Active-high clock inhibit (hold) |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | WIDTH | Parallel word, bit i to stage i |
| ser_out | output | 1 | Last stage (H) |
| ser_out_n | output | 1 | Complement of ser_out |

## Verification
The bound checker tests the following on every clock edge:
- the one-place shift with ser_in entering stage 0;
- the frozen chain under inhibit;
- the cleared chain after reset;
- a loaded chain that matches par_in while load is held;
- complementary outputs.

Three behaviours can only be shown by the bench's scenarios, because they appear at the ports over time or between edges:
- the asynchronous load visible before any edge;
- the order in which a full byte leaves through ser_out;
- the continuation of a stream after an inhibited pause.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_SHIFT = 2'd1,
    STEP_CLEAR = 2'd2
  } step_e;
endpackage

// File: rtl/piso_step_ctrl.sv
module piso_step_ctrl
  import piso_pkg::*;
(
  input  logic  rst,
  input  logic  inhibit,
  output step_e step
);
  // Reset outranks inhibit. Load is handled in the stages themselves.
  always_comb begin
    if (rst)          step = STEP_CLEAR;
    else if (inhibit) step = STEP_HOLD;
    else              step = STEP_SHIFT;
  end
endmodule

// File: rtl/piso_stage.sv
module piso_stage
  import piso_pkg::*;
(
  input  logic  clk,
  input  logic  load_n,
  input  logic  par_bit,
  input  logic  prev_bit,
  input  step_e step,
  output logic  q
);
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) begin
      q <= par_bit;
    end else begin
      case (step)
        STEP_CLEAR: q <= 1'b0;
        STEP_SHIFT: q <= prev_bit;
        default:    q <= q;
      endcase
    end
  end
endmodule

// File: rtl/piso_out_drv.sv
module piso_out_drv (
  input  logic last_stage,
  output logic ser_out,
  output logic ser_out_n
);
  assign ser_out   = last_stage;
  assign ser_out_n = ~last_stage;
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             inhibit,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int LAST = WIDTH - 1;

  step_e            step;
  logic [WIDTH-1:0] stage_q;

  piso_step_ctrl u_ctrl (
    .rst     (rst),
    .inhibit (inhibit),
    .step    (step)
  );

  // R1: stage 0 is the input end, stage LAST drives the output
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic prev;
    if (i == 0) begin : g_head
      assign prev = ser_in;
    end else begin : g_body
      assign prev = stage_q[i-1];
    end
    piso_stage u_stage (
      .clk      (clk),
      .load_n   (load_n),
      .par_bit  (par_in[i]),
      .prev_bit (prev),
      .step     (step),
      .q        (stage_q[i])
    );
  end

  piso_out_drv u_out (
    .last_stage (stage_q[LAST]),
    .ser_out    (ser_out),
    .ser_out_n  (ser_out_n)
  );
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n,
  input logic             inhibit,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage_q,
  input logic             ser_out,
  input logic             ser_out_n
);
  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !inhibit) |=>
      (!load_n || (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0]) &&
                   stage_q[0] == $past(ser_in))));

  // R6
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && inhibit) |=> (!load_n || $stable(stage_q)));

  // R3
  load_match_chk: assert property (@(posedge clk) disable iff (rst)
    !load_n |-> (stage_q == par_in));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(load_n) && load_n) |-> (stage_q == '0));

  // R7
  out_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    ser_out_n != ser_out);

  // R1
  out_tap_chk: assert property (@(posedge clk) disable iff (rst)
    ser_out == stage_q[WIDTH-1]);
endmodule

bind piso_shifter piso_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_n    (load_n),
  .inhibit   (inhibit),
  .ser_in    (ser_in),
  .par_in    (par_in),
  .stage_q   (stage_q),
  .ser_out   (ser_out),
  .ser_out_n (ser_out_n)
);

// File: tb/piso_shifter_bench.sv
module piso_shifter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_n = 1'b1;
  logic       inhibit = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       ser_out, ser_out_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];
  logic [7:0] model = 8'h00;

  always #5 clk = ~clk;

  piso_shifter #(.WIDTH(8)) u_piso_shifter (
    .clk(clk), .rst(rst), .load_n(load_n), .inhibit(inhibit),
    .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out), .ser_out_n(ser_out_n)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: compares the outputs after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_bit(t, ser_out, e);
      check_bit({t, "/R7"}, ser_out_n, ~e);
    end
  end

  // Driver: sets the inputs for the next edge and predicts the result
  task automatic drive(input logic ld_n, input logic [7:0] par, input logic inh,
                       input logic sin, input logic r, input string tag);
    logic was_high;
    @(negedge clk);
    was_high = load_n;
    load_n = ld_n; par_in = par; inhibit = inh; ser_in = sin; rst = r;
    if (!ld_n && was_high) begin
      #1;
      check_bit("R2 async load", ser_out, par[7]);
    end
    if (!ld_n)     model = par;
    else if (r)    model = 8'h00;
    else if (!inh) model = {model[6:0], sin};
    exp_q.push_back(model[7]);
    tag_q.push_back(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] fill;
    // R8 reset state
    for (int i = 0; i < 3; i++) drive(1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, "R8 reset");
    // R3 load held across edges with shift, reset and inhibit present
    drive(1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, "R3 load vs shift");
    drive(1'b0, 8'hA5, 1'b1, 1'b1, 1'b1, "R3 load vs reset");
    // R5 byte order, R4 serial fill
    fill = 8'h3C;
    for (int k = 0; k < 8; k++)
      drive(1'b1, 8'h00, 1'b0, fill[7-k], 1'b0, "R5 byte order");
    for (int k = 0; k < 4; k++)
      drive(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R4 serial fill");
    // R6 inhibit pauses the stream
    drive(1'b0, 8'hC9, 1'b0, 1'b0, 1'b0, "R1 load C9");
    for (int k = 0; k < 10; k++)
      drive(1'b1, 8'h00, k[0], 1'b1, 1'b0, "R6 inhibit");
    // R8 reset overrides inhibit
    drive(1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, "R1 load FF");
    drive(1'b1, 8'h00, 1'b1, 1'b1, 1'b1, "R8 reset over inhibit");
    drive(1'b1, 8'h00, 1'b1, 1'b1, 1'b0, "R6 hold after clear");
    // R1 lowest bit reaches the output last
    drive(1'b0, 8'h01, 1'b0, 1'b0, 1'b0, "R1 load 01");
    for (int k = 0; k < 8; k++)
      drive(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R1 tap order");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule